// File: doc/BRIEF.md
# Call Gate Privilege Transfer Sequencer

This block performs a far control transfer through a call, interrupt or trap gate, and the matching far return. On a call it checks the gate and its target code segment against the current privilege level. It then decides whether the new code runs on the same stack or on an inner stack taken from the per-level slots of the task state. It builds the return frame through a request/acknowledge stack-memory port and reports the new CS:IP, SS:ESP, CPL and flags. When the target is a call gate and the stack switches, it also copies the number of caller parameters given by the gate's word count onto the new stack.

A far return pops the return address, and the flags when the return comes from an interrupt. It discards the caller's parameters by adding an immediate to ESP. When the popped code selector names a less privileged level than the current one, it also pops the saved outer SS:ESP, which moves execution back to the caller's stack. Any protection violation ends the sequence with a one-cycle fault pulse instead of a done pulse.

Top module: `gate_xfer_seq`

## Requirements
- R1: A call faults, with no memory access, when the target is not a code segment, when the gate kind code is 3, or when the target DPL is numerically greater than CPL. The gate kind codes are 0 = call, 1 = interrupt, 2 = trap.
- R2: A call faults, with no memory access, when the gate DPL is numerically smaller than the target DPL.
- R3: A conforming target, or a non-conforming target whose DPL equals CPL, keeps the current SS and CPL. Interrupt and trap gates push flags first. Every call then pushes the caller CS and then the caller IP. Each push decrements ESP by 4 and writes a 32-bit word at the new ESP, with selectors zero-extended.
- R4: A non-conforming target with DPL below CPL switches stacks. The new SS and ESP come from task-state slot number DPL, and slot k sits at bits [16k+15:16k] of the SS slot bus and at bits [32k+31:32k] of the ESP slot bus. The old SS is pushed first, then the old ESP. CPL becomes the target DPL.
- R5: On a stack switch through a call gate, the gate's word count of 32-bit parameters is read from the caller stack and pushed so that their order relative to ESP is kept. The copy comes after the old SS:ESP and before CS. Interrupt and trap gates copy none.
- R6: A completed transfer reports CS as the gate's 14 upper selector bits with the new CPL in bits [1:0], and IP as the gate offset.
- R7: A far return pops IP, then CS from bits [15:0] of the next word, then flags for an interrupt return. Each pop reads at ESP and adds 4. A plain return adds its immediate to ESP after CS, and an interrupt return ignores the immediate.
- R8: When the popped CS RPL is greater than CPL, the return then pops ESP and SS, loads them, and sets CPL to that RPL. Otherwise SS, CPL and the final ESP stay on the current stack.
- R9: A return whose popped CS RPL is below CPL ends with a fault.
- R10: Each memory access keeps its request, address and direction unchanged until the acknowledge arrives, and the sequence does not advance before the acknowledge.
- R11: After reset the block is idle, with no request, no done and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_go | input | 1 | Start a gate call (has priority over ret_go) |
| ret_go | input | 1 | Start a far return |
| gate_kind | input | 2 | 0 call, 1 interrupt, 2 trap, 3 invalid |
| gate_dpl | input | 2 | Privilege level of the gate |
| gate_sel_hi | input | 14 | Target selector index and table bits |
| gate_off | input | 32 | Target offset |
| gate_wc | input | 5 | Parameter word count |
| tgt_code | input | 1 | Target descriptor is a code segment |
| tgt_conf | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Target segment privilege level |
| cur_cpl | input | 2 | Current privilege level |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Return offset |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| cur_flags | input | 32 | Current flags |
| tss_ss_flat | input | 48 | Inner stack selectors, one per level 0..2 |
| tss_esp_flat | input | 96 | Inner stack pointers, one per level 0..2 |
| ret_iret | input | 1 | Return is an interrupt return |
| ret_imm | input | 16 | Bytes to discard on a plain return |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle protection fault pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_ss | output | 16 | Stack selector of the access |
| mem_addr | output | 32 | Stack offset of the access |
| mem_wdata | output | 32 | Write data |
| new_cs | output | 16 | Resulting code selector |
| new_ip | output | 32 | Resulting offset |
| new_ss | output | 16 | Resulting stack selector |
| new_esp | output | 32 | Resulting stack pointer |
| new_cpl | output | 2 | Resulting privilege level |
| new_flags | output | 32 | Resulting flags |

## Verification
The calls in the table cover every gate kind and privilege pairing. An inward non-conforming target tells the stack switch apart from the same-level and conforming cases. Parameter counts of zero and nonzero tell a call gate's copy apart from an interrupt gate, which copies nothing even with a nonzero count. The faulting vectors separate each check: target above CPL, gate below target, non-code target and invalid kind. The returns cover plain and interrupt returns, both with and without the outer-stack unwind, plus an inward return that must fault. The acknowledge latency varies from zero to two cycles, which exercises stalls on every state.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [1:0] {
    GK_CALL = 2'd0,
    GK_INTR = 2'd1,
    GK_TRAP = 2'd2,
    GK_BAD  = 2'd3
  } gate_kind_t;

  typedef enum logic [3:0] {
    S_IDLE     = 4'd0,
    S_PUSH_SS  = 4'd1,
    S_PUSH_ESP = 4'd2,
    S_RD_PRM   = 4'd3,
    S_WR_PRM   = 4'd4,
    S_PUSH_FL  = 4'd5,
    S_PUSH_CS  = 4'd6,
    S_PUSH_IP  = 4'd7,
    S_POP_IP   = 4'd8,
    S_POP_CS   = 4'd9,
    S_POP_FL   = 4'd10,
    S_POP_ESP  = 4'd11,
    S_POP_SS   = 4'd12,
    S_DONE     = 4'd13,
    S_FAULT    = 4'd14
  } seq_state_t;

  typedef struct packed {
    logic       bad;
    logic       switch_stk;
    logic       push_fl;
    logic       copy_prm;
    logic [1:0] new_cpl;
  } gate_verdict_t;

endpackage

// File: rtl/gate_rst_sync.sv
module gate_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/gate_check.sv
module gate_check
  import gate_seq_pkg::*;
(
  input  gate_kind_t    kind,
  input  logic [1:0]    cpl,
  input  logic [1:0]    gate_dpl,
  input  logic          tgt_code,
  input  logic          tgt_conf,
  input  logic [1:0]    tgt_dpl,
  output gate_verdict_t verdict
);
  logic inward;

  always_comb begin
    verdict.bad = (kind == GK_BAD) || !tgt_code ||
                  (tgt_dpl > cpl) || (gate_dpl < tgt_dpl);
    inward = !tgt_conf && (tgt_dpl < cpl);
    verdict.switch_stk = !verdict.bad && inward;
    verdict.push_fl    = (kind != GK_CALL);
    verdict.copy_prm   = (kind == GK_CALL) && inward;
    verdict.new_cpl    = inward ? tgt_dpl : cpl;
  end

  always_comb begin
    if (verdict.switch_stk) begin
      a_inward_lower_r4: assert (verdict.new_cpl < cpl)
        else $error("inward switch without lower level");
    end
  end
endmodule

// File: rtl/gate_slot_mux.sv
module gate_slot_mux #(
  parameter int SLOTS = 3,
  parameter int SW    = 16,
  parameter int AW    = 32,
  parameter int LW    = 2
) (
  input  logic [SLOTS*SW-1:0] ss_flat,
  input  logic [SLOTS*AW-1:0] esp_flat,
  input  logic [LW-1:0]       lvl,
  output logic [SW-1:0]       ss_sel,
  output logic [AW-1:0]       esp_sel
);
  logic [SW-1:0] ss_arr  [SLOTS];
  logic [AW-1:0] esp_arr [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign ss_arr[g]  = ss_flat[g*SW +: SW];
      assign esp_arr[g] = esp_flat[g*AW +: AW];
    end
  endgenerate

  always_comb begin
    ss_sel  = '0;
    esp_sel = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (LW'(k) == lvl) begin
        ss_sel  = ss_arr[k];
        esp_sel = esp_arr[k];
      end
    end
  end
endmodule

// File: rtl/gate_stack_port.sv
module gate_stack_port #(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int WB   = 4
) (
  input  logic          push,
  input  logic          pop,
  input  logic          prm_rd,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] prm_base,
  input  logic [CW-1:0] prm_left,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] sp_step
);
  localparam logic [AW-1:0] STEP = AW'(WB);

  always_comb begin
    if (prm_rd)    addr = prm_base + (AW'(prm_left) - AW'(1)) * STEP;
    else if (push) addr = sp - STEP;
    else           addr = sp;

    if (push)      sp_step = sp - STEP;
    else if (pop)  sp_step = sp + STEP;
    else           sp_step = sp;
  end
endmodule

// File: rtl/gate_xfer_seq.sv
module gate_xfer_seq
  import gate_seq_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int AW    = 32,
  parameter int WC_W  = 5,
  parameter int SLOTS = 3,
  parameter int WB    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  call_go,
  input  logic                  ret_go,
  input  logic [1:0]            gate_kind,
  input  logic [1:0]            gate_dpl,
  input  logic [SEL_W-3:0]      gate_sel_hi,
  input  logic [AW-1:0]         gate_off,
  input  logic [WC_W-1:0]       gate_wc,
  input  logic                  tgt_code,
  input  logic                  tgt_conf,
  input  logic [1:0]            tgt_dpl,
  input  logic [1:0]            cur_cpl,
  input  logic [SEL_W-1:0]      cur_cs,
  input  logic [AW-1:0]         cur_ip,
  input  logic [SEL_W-1:0]      cur_ss,
  input  logic [AW-1:0]         cur_esp,
  input  logic [AW-1:0]         cur_flags,
  input  logic [SLOTS*SEL_W-1:0] tss_ss_flat,
  input  logic [SLOTS*AW-1:0]   tss_esp_flat,
  input  logic                  ret_iret,
  input  logic [15:0]           ret_imm,
  input  logic                  mem_ack,
  input  logic [AW-1:0]         mem_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [SEL_W-1:0]      mem_ss,
  output logic [AW-1:0]         mem_addr,
  output logic [AW-1:0]         mem_wdata,
  output logic [SEL_W-1:0]      new_cs,
  output logic [AW-1:0]         new_ip,
  output logic [SEL_W-1:0]      new_ss,
  output logic [AW-1:0]         new_esp,
  output logic [1:0]            new_cpl,
  output logic [AW-1:0]         new_flags
);
  localparam int PL_W = 2;
  localparam logic [AW-1:0] STEP = AW'(WB);

  logic srst_n;
  seq_state_t state_q, state_d;
  gate_verdict_t vd;

  logic [AW-1:0]    sp_q, hold_esp_q, old_esp_q;
  logic [SEL_W-1:0] work_ss_q, old_ss_q, ret_cs_q;
  logic [AW-1:0]    ret_ip_q, flags_q, prm_data_q;
  logic [WC_W-1:0]  prm_left_q;
  logic             push_fl_q, copy_q, iret_q;
  logic [1:0]       cpl_q;
  logic [15:0]      imm_q;
  logic [SEL_W-1:0] res_cs_q;
  logic [AW-1:0]    res_ip_q, res_flags_q;
  logic [1:0]       res_cpl_q;

  logic [SEL_W-1:0] slot_ss;
  logic [AW-1:0]    slot_esp;
  logic             st_push, st_pop, st_prm_rd;
  logic [AW-1:0]    sp_step;
  logic             xfer, go_call, go_ret;
  logic [1:0]       pop_rpl;

  gate_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gate_check u_chk (
    .kind     (gate_kind_t'(gate_kind)),
    .cpl      (cur_cpl),
    .gate_dpl (gate_dpl),
    .tgt_code (tgt_code),
    .tgt_conf (tgt_conf),
    .tgt_dpl  (tgt_dpl),
    .verdict  (vd)
  );

  gate_slot_mux #(.SLOTS(SLOTS), .SW(SEL_W), .AW(AW), .LW(PL_W)) u_slot (
    .ss_flat  (tss_ss_flat),
    .esp_flat (tss_esp_flat),
    .lvl      (tgt_dpl),
    .ss_sel   (slot_ss),
    .esp_sel  (slot_esp)
  );

  always_comb begin
    st_push   = (state_q == S_PUSH_SS) || (state_q == S_PUSH_ESP) ||
                (state_q == S_WR_PRM)  || (state_q == S_PUSH_FL)  ||
                (state_q == S_PUSH_CS) || (state_q == S_PUSH_IP);
    st_pop    = (state_q == S_POP_IP)  || (state_q == S_POP_CS) ||
                (state_q == S_POP_FL)  || (state_q == S_POP_ESP) ||
                (state_q == S_POP_SS);
    st_prm_rd = (state_q == S_RD_PRM);
  end

  gate_stack_port #(.AW(AW), .CW(WC_W), .WB(WB)) u_port (
    .push     (st_push),
    .pop      (st_pop),
    .prm_rd   (st_prm_rd),
    .sp       (sp_q),
    .prm_base (old_esp_q),
    .prm_left (prm_left_q),
    .addr     (mem_addr),
    .sp_step  (sp_step)
  );

  assign mem_req = st_push || st_pop || st_prm_rd;
  assign mem_we  = st_push;
  assign mem_ss  = st_prm_rd ? old_ss_q : work_ss_q;
  assign xfer    = mem_req && mem_ack;
  assign go_call = (state_q == S_IDLE) && call_go;
  assign go_ret  = (state_q == S_IDLE) && ret_go && !call_go;
  assign pop_rpl = mem_rdata[PL_W-1:0];

  always_comb begin
    unique case (state_q)
      S_PUSH_SS:  mem_wdata = AW'(old_ss_q);
      S_PUSH_ESP: mem_wdata = old_esp_q;
      S_WR_PRM:   mem_wdata = prm_data_q;
      S_PUSH_FL:  mem_wdata = flags_q;
      S_PUSH_CS:  mem_wdata = AW'(ret_cs_q);
      S_PUSH_IP:  mem_wdata = ret_ip_q;
      default:    mem_wdata = '0;
    endcase
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (call_go) begin
          if (vd.bad)             state_d = S_FAULT;
          else if (vd.switch_stk) state_d = S_PUSH_SS;
          else if (vd.push_fl)    state_d = S_PUSH_FL;
          else                    state_d = S_PUSH_CS;
        end else if (ret_go) begin
          state_d = S_POP_IP;
        end
      end
      S_PUSH_SS:  if (mem_ack) state_d = S_PUSH_ESP;
      S_PUSH_ESP: if (mem_ack) begin
        if (copy_q && (prm_left_q != '0)) state_d = S_RD_PRM;
        else if (push_fl_q)               state_d = S_PUSH_FL;
        else                              state_d = S_PUSH_CS;
      end
      S_RD_PRM:   if (mem_ack) state_d = S_WR_PRM;
      S_WR_PRM:   if (mem_ack) begin
        if (prm_left_q == WC_W'(1)) state_d = push_fl_q ? S_PUSH_FL : S_PUSH_CS;
        else                        state_d = S_RD_PRM;
      end
      S_PUSH_FL:  if (mem_ack) state_d = S_PUSH_CS;
      S_PUSH_CS:  if (mem_ack) state_d = S_PUSH_IP;
      S_PUSH_IP:  if (mem_ack) state_d = S_DONE;
      S_POP_IP:   if (mem_ack) state_d = S_POP_CS;
      S_POP_CS:   if (mem_ack) begin
        if (pop_rpl < cpl_q)      state_d = S_FAULT;
        else if (iret_q)          state_d = S_POP_FL;
        else if (pop_rpl > cpl_q) state_d = S_POP_ESP;
        else                      state_d = S_DONE;
      end
      S_POP_FL:   if (mem_ack) state_d = (res_cs_q[PL_W-1:0] > cpl_q) ? S_POP_ESP : S_DONE;
      S_POP_ESP:  if (mem_ack) state_d = S_POP_SS;
      S_POP_SS:   if (mem_ack) state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      S_FAULT:    state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // capture of call/return context, enabled only at start
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      old_ss_q  <= '0;
      old_esp_q <= '0;
      ret_cs_q  <= '0;
      ret_ip_q  <= '0;
      flags_q   <= '0;
      push_fl_q <= 1'b0;
      copy_q    <= 1'b0;
      iret_q    <= 1'b0;
      cpl_q     <= '0;
      imm_q     <= '0;
    end else begin
      if (go_call) begin
        old_ss_q  <= cur_ss;
        old_esp_q <= cur_esp;
        ret_cs_q  <= cur_cs;
        ret_ip_q  <= cur_ip;
        flags_q   <= cur_flags;
        push_fl_q <= vd.push_fl;
        copy_q    <= vd.copy_prm;
        cpl_q     <= cur_cpl;
      end
      if (go_ret) begin
        iret_q    <= ret_iret;
        imm_q     <= ret_imm;
        cpl_q     <= cur_cpl;
        push_fl_q <= 1'b0;
        copy_q    <= 1'b0;
      end
    end
  end

  // stack pointer, stack selector and parameter copy datapath
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sp_q       <= '0;
      work_ss_q  <= '0;
      hold_esp_q <= '0;
      prm_left_q <= '0;
      prm_data_q <= '0;
    end else begin
      if (go_call) begin
        prm_left_q <= gate_wc;
        if (vd.switch_stk) begin
          sp_q      <= slot_esp;
          work_ss_q <= slot_ss;
        end else begin
          sp_q      <= cur_esp;
          work_ss_q <= cur_ss;
        end
      end else if (go_ret) begin
        sp_q      <= cur_esp;
        work_ss_q <= cur_ss;
      end else if (xfer) begin
        unique case (state_q)
          S_RD_PRM:  prm_data_q <= mem_rdata;
          S_WR_PRM: begin
            sp_q       <= sp_step;
            prm_left_q <= prm_left_q - WC_W'(1);
          end
          S_POP_CS:  sp_q <= iret_q ? sp_step : (sp_step + AW'(imm_q));
          S_POP_ESP: begin
            hold_esp_q <= mem_rdata;
            sp_q       <= sp_step;
          end
          S_POP_SS: begin
            work_ss_q <= mem_rdata[SEL_W-1:0];
            sp_q      <= hold_esp_q;
          end
          default:   sp_q <= sp_step;
        endcase
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_cs_q    <= '0;
      res_ip_q    <= '0;
      res_flags_q <= '0;
      res_cpl_q   <= '0;
    end else begin
      if (go_call) begin
        res_cs_q    <= {gate_sel_hi, vd.new_cpl};
        res_ip_q    <= gate_off;
        res_flags_q <= cur_flags;
        res_cpl_q   <= vd.new_cpl;
      end else if (go_ret) begin
        res_flags_q <= cur_flags;
      end else if (xfer) begin
        if (state_q == S_POP_IP) res_ip_q <= mem_rdata;
        if (state_q == S_POP_CS) begin
          res_cs_q  <= mem_rdata[SEL_W-1:0];
          res_cpl_q <= pop_rpl;
        end
        if (state_q == S_POP_FL) res_flags_q <= mem_rdata;
      end
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign fault     = (state_q == S_FAULT);
  assign new_cs    = res_cs_q;
  assign new_ip    = res_ip_q;
  assign new_ss    = work_ss_q;
  assign new_esp   = sp_q;
  assign new_cpl   = res_cpl_q;
  assign new_flags = res_flags_q;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
    else $error("request dropped or changed before acknowledge");

  p_bad_gate_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (go_call && vd.bad) |=> (fault && !mem_req))
    else $error("invalid gate did not fault at once");

  p_cs_rpl_r6: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (new_cs[PL_W-1:0] == new_cpl))
    else $error("code selector RPL differs from CPL");

  p_inward_cpl_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (go_call && vd.switch_stk) |=> (new_cpl < $past(cur_cpl)))
    else $error("stack switch did not lower CPL");

  p_outer_ss_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == S_POP_SS && mem_ack) |=> (new_ss == $past(mem_rdata[SEL_W-1:0])))
    else $error("outer SS not restored from stack");
endmodule

// File: tb/tb_gate_xfer_seq.sv
module tb_gate_xfer_seq;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        call_go, ret_go, tgt_code, tgt_conf, ret_iret, mem_ack;
  logic [1:0]  gate_kind, gate_dpl, tgt_dpl, cur_cpl;
  logic [13:0] gate_sel_hi;
  logic [31:0] gate_off, cur_ip, cur_esp, cur_flags, mem_rdata;
  logic [4:0]  gate_wc;
  logic [15:0] cur_cs, cur_ss, ret_imm;
  logic [47:0] tss_ss_flat;
  logic [95:0] tss_esp_flat;
  logic        busy, done, fault, mem_req, mem_we;
  logic [15:0] mem_ss, new_cs, new_ss;
  logic [31:0] mem_addr, mem_wdata, new_ip, new_esp, new_flags;
  logic [1:0]  new_cpl;

  gate_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .call_go(call_go), .ret_go(ret_go),
    .gate_kind(gate_kind), .gate_dpl(gate_dpl), .gate_sel_hi(gate_sel_hi),
    .gate_off(gate_off), .gate_wc(gate_wc), .tgt_code(tgt_code),
    .tgt_conf(tgt_conf), .tgt_dpl(tgt_dpl), .cur_cpl(cur_cpl),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_esp(cur_esp),
    .cur_flags(cur_flags), .tss_ss_flat(tss_ss_flat),
    .tss_esp_flat(tss_esp_flat), .ret_iret(ret_iret), .ret_imm(ret_imm),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fault(fault), .mem_req(mem_req), .mem_we(mem_we), .mem_ss(mem_ss),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .new_cs(new_cs),
    .new_ip(new_ip), .new_ss(new_ss), .new_esp(new_esp),
    .new_cpl(new_cpl), .new_flags(new_flags)
  );

  // stack memory model: 256 words, variable acknowledge latency
  logic [31:0] mem_w [256];
  int lat;
  int wait_n;
  int acc_n;
  assign mem_rdata = mem_w[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_n  <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      wait_n  <= 0;
      acc_n   <= acc_n + 1;
      if (mem_we) mem_w[mem_addr[9:2]] = mem_wdata;
    end else if (mem_req) begin
      if (wait_n >= lat) mem_ack <= 1'b1;
      else               wait_n <= wait_n + 1;
    end
  end

  // stall monitor for R10
  int viol = 0;
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we))
      viol = viol + 1;
    p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_we = mem_we;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic got_done, got_fault;

  task automatic run_op(input bit is_call);
    int k;
    acc_n = 0;
    @(negedge clk);
    if (is_call) call_go = 1'b1; else ret_go = 1'b1;
    @(negedge clk);
    call_go = 1'b0; ret_go = 1'b0;
    k = 0;
    while (!(done || fault) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    got_done = done;
    got_fault = fault;
    if (k >= 2000) chk("R10 op timeout", 32'd1, 32'd0);
  endtask

  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] cpl;
    logic [1:0] gdpl;
    logic [1:0] tdpl;
    logic       code;
    logic       conf;
    logic [2:0] wc;
    logic       efault;
    logic       esw;
    logic [1:0] ecpl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 2'd0}, // R4 R5 call inward
    '{2'd1, 2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 2'd0}, // R5 intr copies none
    '{2'd2, 2'd2, 2'd3, 2'd1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd1}, // R4 trap slot 1
    '{2'd0, 2'd1, 2'd1, 2'd1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 2'd1}, // R3 same level
    '{2'd0, 2'd3, 2'd3, 2'd1, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 2'd3}, // R3 conforming
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 2'd0}, // R3 intr same level
    '{2'd0, 2'd1, 2'd2, 2'd2, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 2'd0}, // R1 target above CPL
    '{2'd0, 2'd3, 2'd0, 2'd1, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 2'd0}, // R2 gate below target
    '{2'd0, 2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 2'd0}, // R1 not code
    '{2'd3, 2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 2'd0}, // R1 bad kind
    '{2'd0, 2'd2, 2'd2, 2'd1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 2'd1}  // R5 four params
  };

  function automatic logic [31:0] slot_esp_of(input int s);
    return 32'h2F0 - 32'h100 * s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    call_go = 0; ret_go = 0; gate_kind = 0; gate_dpl = 0; gate_sel_hi = 0;
    gate_off = 0; gate_wc = 0; tgt_code = 0; tgt_conf = 0; tgt_dpl = 0;
    cur_cpl = 0; cur_cs = 0; cur_ip = 0; cur_ss = 0; cur_esp = 0;
    cur_flags = 0; ret_iret = 0; ret_imm = 0; lat = 0; acc_n = 0;
    for (int a = 0; a < 256; a++) mem_w[a] = 32'h0;
    for (int s = 0; s < 3; s++) begin
      tss_ss_flat[16*s +: 16]  = 16'h0010 + 16'(8 * s);
      tss_esp_flat[32*s +: 32] = slot_esp_of(s);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 fault", 32'(fault), 32'd0);
    chk("R11 mem_req", 32'(mem_req), 32'd0);

    // table of calls
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int fl, wce, n, word;
      logic [31:0] base, ee, pb;
      v = VECS[i];
      lat = i % 3;
      gate_kind = v.kind; gate_dpl = v.gdpl; tgt_dpl = v.tdpl;
      tgt_code = v.code; tgt_conf = v.conf; gate_wc = 5'(v.wc);
      cur_cpl = v.cpl; cur_cs = {14'h5, v.cpl}; cur_ip = 32'h4400 + i;
      cur_ss = 16'h0023; cur_esp = 32'h3F0; cur_flags = 32'h202 + i;
      gate_sel_hi = 14'h40 + 14'(i); gate_off = 32'h8000_0000 + 32'h100 * i;
      for (int j = 0; j < 4; j++) mem_w[(32'h3F0 >> 2) + j] = 32'hA000_0000 + 16 * i + j;
      run_op(1'b1);
      if (v.efault) begin
        chk($sformatf("R1 R2 fault vec%0d", i), 32'(got_fault), 32'd1);
        chk($sformatf("R1 R2 no access vec%0d", i), acc_n, 32'd0);
      end else begin
        fl  = (v.kind != 2'd0) ? 1 : 0;
        wce = (v.esw && v.kind == 2'd0) ? int'(v.wc) : 0;
        n   = (v.esw ? 2 : 0) + wce + fl + 2;
        base = v.esw ? slot_esp_of(int'(v.tdpl)) : 32'h3F0;
        ee   = base - 32'(4 * n);
        chk($sformatf("R3 done vec%0d", i), 32'(got_done), 32'd1);
        chk($sformatf("R4 cpl vec%0d", i), 32'(new_cpl), 32'(v.ecpl));
        chk($sformatf("R6 cs vec%0d", i), 32'(new_cs), 32'({gate_sel_hi, v.ecpl}));
        chk($sformatf("R6 ip vec%0d", i), new_ip, gate_off);
        chk($sformatf("R4 ss vec%0d", i), 32'(new_ss),
            v.esw ? 32'(16'h0010 + 16'(8 * v.tdpl)) : 32'h23);
        chk($sformatf("R3 esp vec%0d", i), new_esp, ee);
        chk($sformatf("R5 accesses vec%0d", i), acc_n, 32'(n + wce));
        word = int'(ee[9:2]);
        chk($sformatf("R3 ip slot vec%0d", i), mem_w[word], cur_ip);
        chk($sformatf("R3 cs slot vec%0d", i), mem_w[word + 1], 32'(cur_cs));
        if (fl == 1) chk($sformatf("R3 flags slot vec%0d", i), mem_w[word + 2], cur_flags);
        if (v.esw) begin
          pb = ee + 32'(8 + 4 * fl);
          for (int j = 0; j < wce; j++)
            chk($sformatf("R5 param%0d vec%0d", j, i), mem_w[pb[9:2] + j],
                32'hA000_0000 + 16 * i + j);
          chk($sformatf("R4 old esp vec%0d", i), mem_w[base[9:2] - 2], 32'h3F0);
          chk($sformatf("R4 old ss vec%0d", i), mem_w[base[9:2] - 1], 32'h23);
        end
      end
      @(negedge clk);
    end

    // returns
    lat = 1;
    // R7 plain return, same level, immediate 8
    mem_w[32'h3C0 >> 2] = 32'h1234; mem_w[(32'h3C0 >> 2) + 1] = 32'hFFFF_0012;
    cur_cpl = 2'd2; cur_esp = 32'h3C0; cur_ss = 16'h002A; cur_flags = 32'h2;
    ret_iret = 1'b0; ret_imm = 16'd8;
    run_op(1'b0);
    chk("R7 done", 32'(got_done), 32'd1);
    chk("R7 ip", new_ip, 32'h1234);
    chk("R7 cs low half", 32'(new_cs), 32'h12);
    chk("R7 esp plus imm", new_esp, 32'h3D0);
    chk("R8 same ss", 32'(new_ss), 32'h2A);
    chk("R8 same cpl", 32'(new_cpl), 32'd2);
    chk("R7 flags kept", new_flags, 32'h2);
    @(negedge clk);

    // R7 interrupt return, same level, immediate ignored
    mem_w[32'h3C0 >> 2] = 32'h5678; mem_w[(32'h3C0 >> 2) + 1] = 32'h0008;
    mem_w[(32'h3C0 >> 2) + 2] = 32'h246;
    cur_cpl = 2'd0; ret_iret = 1'b1; ret_imm = 16'd12;
    run_op(1'b0);
    chk("R7 iret ip", new_ip, 32'h5678);
    chk("R7 iret flags", new_flags, 32'h246);
    chk("R7 iret imm ignored", new_esp, 32'h3CC);
    chk("R7 iret accesses", acc_n, 32'd3);
    @(negedge clk);

    // R8 plain return to outer level
    lat = 2;
    mem_w[32'h3C0 >> 2] = 32'h9ABC; mem_w[(32'h3C0 >> 2) + 1] = 32'h001B;
    mem_w[(32'h3D0 >> 2)] = 32'h3A0; mem_w[(32'h3D0 >> 2) + 1] = 32'h002B;
    cur_cpl = 2'd0; ret_iret = 1'b0; ret_imm = 16'd8;
    run_op(1'b0);
    chk("R8 outer done", 32'(got_done), 32'd1);
    chk("R8 outer esp", new_esp, 32'h3A0);
    chk("R8 outer ss", 32'(new_ss), 32'h2B);
    chk("R8 outer cpl", 32'(new_cpl), 32'd3);
    chk("R8 outer accesses", acc_n, 32'd4);
    @(negedge clk);

    // R8 interrupt return to outer level
    lat = 0;
    mem_w[32'h3C0 >> 2] = 32'h0111; mem_w[(32'h3C0 >> 2) + 1] = 32'h0022;
    mem_w[(32'h3C0 >> 2) + 2] = 32'h0202; mem_w[(32'h3C0 >> 2) + 3] = 32'h0380;
    mem_w[(32'h3C0 >> 2) + 4] = 32'h0033;
    cur_cpl = 2'd1; ret_iret = 1'b1; ret_imm = 16'd4;
    run_op(1'b0);
    chk("R8 iret outer cpl", 32'(new_cpl), 32'd2);
    chk("R8 iret outer esp", new_esp, 32'h380);
    chk("R8 iret outer ss", 32'(new_ss), 32'h33);
    chk("R8 iret outer flags", new_flags, 32'h202);
    @(negedge clk);

    // R9 return to more privileged level
    mem_w[32'h3C0 >> 2] = 32'h0777; mem_w[(32'h3C0 >> 2) + 1] = 32'h0010;
    cur_cpl = 2'd3; ret_iret = 1'b0; ret_imm = 16'd0;
    run_op(1'b0);
    chk("R9 inward return fault", 32'(got_fault), 32'd1);
    chk("R9 no done", 32'(got_done), 32'd0);
    @(negedge clk);

    chk("R10 request held across stalls", viol, 32'd0);
    chk("R11 idle after all", 32'(busy), 32'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule